// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup Pipeline

This block is the lookup path of a set-associative cache. The set is chosen from address bits that sit inside the page offset. Those bits are the same before and after translation, so the tag and data arrays can be read from the virtual address. In the same cycle, an external translator resolves the virtual page into a physical page number. At the next clock edge a pipeline register captures three things: the tag of every way, the valid bit of every way, and the addressed word of every way, together with the translated page number. In the second stage each stored tag is compared with the physical page number. The word from the way that matches is then returned to the processor.

Accepting a request takes one cycle, and a new request may arrive in every cycle. The result appears on the outputs in the cycle after the request. A refill port writes a whole line in a single cycle. The way it writes is chosen in this order:

1. The way that already holds the same physical tag.
2. Otherwise, the lowest-numbered invalid way.
3. Otherwise, the way named by a round-robin pointer kept for each set.

Defaults: two ways, 32 sets, 64-byte lines and a 4 KB page. With these defaults, line offset and set index use address bits [10:0].

Top module: `vipt_lookup_cache`

## Requirements
- R1: After reset every line is invalid: rspValid is low until a request is made, and every lookup misses until a refill has been performed.
- R2: rspValid is high in exactly the cycles that follow a cycle with reqValid high, so that one lookup can complete in every cycle.
- R3: The set index is reqVaddr[10:6] and the word is reqVaddr[5:2]. Every virtual bit from 11 upward has no effect on the result. The only tag used for the comparison is xlatPpn, sampled in the same cycle as the request.
- R4: A lookup hits when a valid way of the indexed set stores a tag equal to xlatPpn. In that case rspData is word reqVaddr[5:2] of that line, where word i is refillLine[32*i+31:32*i].
- R5: On a miss rspHit is 0, and rspData and rspWay are both 0. When rspValid is low all three are 0.
- R6: On a hit rspWay gives the index of the way that holds the line.
- R7: When refillValid is high, the line is written at that clock edge. The set is refillPaddr[10:6] and the tag is refillPaddr[31:12]. A lookup in the same cycle sees the contents from before the write. Lookups in later cycles see the new line.
- R8: A refill whose tag is not present goes into the lowest-numbered invalid way of its set.
- R9: When every way of the set is valid and the tag is not present, the refill replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and then advances by one, wrapping at the way count. Each set has its own pointer.
- R10: A refill whose tag is already valid in the set overwrites that same way. It does not touch the replacement pointer.
- R11: At most one way matches in any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address of the lookup |
| xlatPpn | input | 20 | Physical page number from the translator, in the request cycle |
| refillValid | input | 1 | Line write strobe |
| refillPaddr | input | 32 | Physical address of the line being written |
| refillLine | input | 512 | Line contents, word i at bits [32i+31:32i] |
| rspValid | output | 1 | Result present, one cycle after a request |
| rspHit | output | 1 | Lookup hit |
| rspWay | output | 1 | Index of the hitting way |
| rspData | output | 32 | Addressed word of the hitting line |

## Verification
The following are checked by assertions on every clock:
- the one-cycle relation between requests and results;
- no more than one tag match;
- quiet outputs on a miss;
- no hit before the first refill;
- the victim choice at each refill: a matching way first, then an invalid way.

Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model:
- the round-robin order within each set and the independence of sets;
- the returned word and way;
- a lookup and a refill in the same cycle, where the lookup must see the old line;
- tolerance of differing virtual page bits.

// File: rtl/vipt_lookup_pkg.sv
package vipt_lookup_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic captureReq;   // load the stage-1 registers with this request
    logic writeLine;    // write refill line into the chosen way
  } vlStrobe_t;

endpackage

// File: rtl/vipt_lookup_ctrl.sv
module vipt_lookup_ctrl
  import vipt_lookup_pkg::*;
#(
  parameter int WAYS    = 2,
  parameter int SETS    = 32,
  parameter int WAY_W   = 1,
  parameter int INDEX_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               refillValid,
  input  logic [INDEX_W-1:0] refillIdx,
  input  logic [WAYS-1:0]    refillSetValid,
  input  logic [WAYS-1:0]    refillMatch,
  output vlStrobe_t          strobes,
  output logic [WAY_W-1:0]   victimWay
);

  logic [WAY_W-1:0] rrPtr [SETS];
  logic [WAY_W-1:0] matchWay;
  logic [WAY_W-1:0] freeWay;
  logic             anyMatch;
  logic             allValid;
  logic             advanceRr;

  assign anyMatch = |refillMatch;
  assign allValid = &refillSetValid;

  // Lowest-numbered way with a matching tag / without a valid line
  always_comb begin
    matchWay = '0;
    freeWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (refillMatch[w])     matchWay = WAY_W'(w);
      if (!refillSetValid[w]) freeWay  = WAY_W'(w);
    end
  end

  always_comb begin
    if (anyMatch)       victimWay = matchWay;
    else if (!allValid) victimWay = freeWay;
    else                victimWay = rrPtr[refillIdx];
  end

  assign advanceRr          = refillValid && !anyMatch && allValid;
  assign strobes.captureReq = reqValid;
  assign strobes.writeLine  = refillValid;

  // Per-set round-robin pointers
  generate
    for (genvar s = 0; s < SETS; s++) begin : gRr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rrPtr[s] <= '0;
        end else if (advanceRr && (refillIdx == INDEX_W'(s))) begin
          if (rrPtr[s] == WAY_W'(WAYS - 1)) rrPtr[s] <= '0;
          else                              rrPtr[s] <= rrPtr[s] + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vipt_lookup_datapath.sv
module vipt_lookup_datapath
  import vipt_lookup_pkg::*;
#(
  parameter int WAYS      = 2,
  parameter int SETS      = 32,
  parameter int WAY_W     = 1,
  parameter int INDEX_W   = 5,
  parameter int WORDSEL_W = 4,
  parameter int WORD_W    = 32,
  parameter int LINE_W    = 512,
  parameter int PPN_W     = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vlStrobe_t            strobes,
  input  logic [WAY_W-1:0]     victimWay,
  input  logic [INDEX_W-1:0]   reqIdx,
  input  logic [WORDSEL_W-1:0] reqWord,
  input  logic [PPN_W-1:0]     xlatPpn,
  input  logic [INDEX_W-1:0]   refillIdx,
  input  logic [PPN_W-1:0]     refillTag,
  input  logic [LINE_W-1:0]    refillLine,
  output logic [WAYS-1:0]      refillSetValid,
  output logic [WAYS-1:0]      refillMatch,
  output logic [WAYS-1:0]      hitVec,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [WAY_W-1:0]     rspWay,
  output logic [WORD_W-1:0]    rspData
);

  // Storage arrays
  logic [LINE_W-1:0] lineMem [WAYS][SETS];
  logic [PPN_W-1:0]  tagMem  [WAYS][SETS];
  logic [WAYS-1:0][SETS-1:0] validBits;

  // Stage-0 reads, one per way
  logic [WAYS-1:0][PPN_W-1:0]  rdTag;
  logic [WAYS-1:0][WORD_W-1:0] rdWord;
  logic [WAYS-1:0]             rdVld;

  // Stage-1 registers (pipeline boundary)
  logic                        s1Valid;
  logic [PPN_W-1:0]            s1Ppn;
  logic [WAYS-1:0][PPN_W-1:0]  s1Tag;
  logic [WAYS-1:0][WORD_W-1:0] s1Word;
  logic [WAYS-1:0]             s1Vld;

  always_ff @(posedge clk) begin
    if (strobes.writeLine) begin
      lineMem[victimWay][refillIdx] <= refillLine;
      tagMem[victimWay][refillIdx]  <= refillTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strobes.writeLine) begin
      validBits[victimWay][refillIdx] <= 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : gWay
      logic [LINE_W-1:0] rdLine;
      assign rdLine    = lineMem[w][reqIdx];
      assign rdTag[w]  = tagMem[w][reqIdx];
      assign rdVld[w]  = validBits[w][reqIdx];
      assign rdWord[w] = rdLine[reqWord*WORD_W +: WORD_W];

      // Refill-side probe of the target set
      assign refillSetValid[w] = validBits[w][refillIdx];
      assign refillMatch[w]    = validBits[w][refillIdx] &&
                                 (tagMem[w][refillIdx] == refillTag);

      // Stage-1 compare against translated page number
      assign hitVec[w] = s1Valid && s1Vld[w] && (s1Tag[w] == s1Ppn);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Vld   <= '0;
    end else begin
      s1Valid <= strobes.captureReq;
      if (strobes.captureReq) s1Vld <= rdVld;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.captureReq) begin
      s1Ppn  <= xlatPpn;
      s1Tag  <= rdTag;
      s1Word <= rdWord;
    end
  end

  // AND-OR way select; hit vector is at most one-hot
  always_comb begin
    rspData = '0;
    rspWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        rspData = rspData | s1Word[w];
        rspWay  = rspWay  | WAY_W'(w);
      end
    end
  end

  assign rspValid = s1Valid;
  assign rspHit   = |hitVec;

endmodule

// File: rtl/vipt_lookup_cache.sv
module vipt_lookup_cache
  import vipt_lookup_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 32,
  parameter int WORD_W     = 32
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic                                           reqValid,
  input  logic [VADDR_W-1:0]                             reqVaddr,
  input  logic [PADDR_W-$clog2(PAGE_BYTES)-1:0]          xlatPpn,
  input  logic                                           refillValid,
  input  logic [PADDR_W-1:0]                             refillPaddr,
  input  logic [LINE_BYTES*8-1:0]                        refillLine,
  output logic                                           rspValid,
  output logic                                           rspHit,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]     rspWay,
  output logic [WORD_W-1:0]                              rspData
);

  localparam int PAGE_W      = $clog2(PAGE_BYTES);
  localparam int PPN_W       = PADDR_W - PAGE_W;
  localparam int OFFSET_W    = $clog2(LINE_BYTES);
  localparam int INDEX_W     = $clog2(SETS);
  localparam int LINE_W      = LINE_BYTES * 8;
  localparam int WORD_BYTE_W = $clog2(WORD_W / 8);
  localparam int WORDSEL_W   = OFFSET_W - WORD_BYTE_W;
  localparam int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Address slicing: index and word come from untranslated bits only
  logic [INDEX_W-1:0]   reqIdx;
  logic [WORDSEL_W-1:0] reqWord;
  logic [INDEX_W-1:0]   refillIdx;
  logic [PPN_W-1:0]     refillTag;
  logic                 unusedAddrBits;

  assign reqIdx    = reqVaddr[OFFSET_W +: INDEX_W];
  assign reqWord   = reqVaddr[WORD_BYTE_W +: WORDSEL_W];
  assign refillIdx = refillPaddr[OFFSET_W +: INDEX_W];
  assign refillTag = refillPaddr[PAGE_W +: PPN_W];
  assign unusedAddrBits = ^{reqVaddr[VADDR_W-1:OFFSET_W+INDEX_W],
                            reqVaddr[WORD_BYTE_W-1:0],
                            refillPaddr[PAGE_W-1:OFFSET_W+INDEX_W],
                            refillPaddr[OFFSET_W-1:0]};

  vlStrobe_t         strobes;
  logic [WAY_W-1:0]  victimWay;
  logic [WAYS-1:0]   refillSetValid;
  logic [WAYS-1:0]   refillMatch;
  logic [WAYS-1:0]   hitVec;

  vipt_lookup_ctrl #(
    .WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .INDEX_W(INDEX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .refillValid(refillValid), .refillIdx(refillIdx),
    .refillSetValid(refillSetValid), .refillMatch(refillMatch),
    .strobes(strobes), .victimWay(victimWay)
  );

  vipt_lookup_datapath #(
    .WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .INDEX_W(INDEX_W),
    .WORDSEL_W(WORDSEL_W), .WORD_W(WORD_W), .LINE_W(LINE_W), .PPN_W(PPN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .victimWay(victimWay),
    .reqIdx(reqIdx), .reqWord(reqWord), .xlatPpn(xlatPpn),
    .refillIdx(refillIdx), .refillTag(refillTag), .refillLine(refillLine),
    .refillSetValid(refillSetValid), .refillMatch(refillMatch), .hitVec(hitVec),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay), .rspData(rspData)
  );

endmodule

// File: rtl/vipt_lookup_checker.sv
module vipt_lookup_checker #(
  parameter int WAYS   = 2,
  parameter int WAY_W  = 1,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              refillValid,
  input logic              rspValid,
  input logic              rspHit,
  input logic [WAY_W-1:0]  rspWay,
  input logic [WORD_W-1:0] rspData,
  input logic [WAYS-1:0]   hitVec,
  input logic              writeLine,
  input logic [WAY_W-1:0]  victimWay,
  input logic [WAYS-1:0]   refillSetValid,
  input logic [WAYS-1:0]   refillMatch
);

  logic refillSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            refillSeen <= 1'b0;
    else if (refillValid) refillSeen <= 1'b1;
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_cold_miss_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> refillSeen);

  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspData == '0) && (rspWay == '0));

  assert_single_hit_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_hit_way_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> hitVec[rspWay]);

  assert_invalid_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (writeLine && !(|refillMatch) && !(&refillSetValid)) |-> !refillSetValid[victimWay]);

  assert_reuse_match_R10: assert property (@(posedge clk) disable iff (!rstN)
    (writeLine && (|refillMatch)) |-> refillMatch[victimWay]);

endmodule

bind vipt_lookup_cache vipt_lookup_checker #(
  .WAYS(WAYS), .WAY_W(WAY_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .refillValid(refillValid),
  .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay), .rspData(rspData),
  .hitVec(hitVec), .writeLine(strobes.writeLine), .victimWay(victimWay),
  .refillSetValid(refillSetValid), .refillMatch(refillMatch)
);

// File: tb/vipt_lookup_cache_tb.sv
module vipt_lookup_cache_tb_top;

  localparam int NW = 2;
  localparam int NS = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [31:0]  reqVaddr;
  logic [19:0]  xlatPpn;
  logic         refillValid;
  logic [31:0]  refillPaddr;
  logic [511:0] refillLine;
  logic         rspValid;
  logic         rspHit;
  logic [0:0]   rspWay;
  logic [31:0]  rspData;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;   // 50 MHz

  vipt_lookup_cache dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .xlatPpn(xlatPpn), .refillValid(refillValid), .refillPaddr(refillPaddr),
    .refillLine(refillLine), .rspValid(rspValid), .rspHit(rspHit),
    .rspWay(rspWay), .rspData(rspData)
  );

  // Behavioural reference model
  bit [511:0] mLine  [NW][NS];
  bit [19:0]  mTag   [NW][NS];
  bit         mValid [NW][NS];
  int         mRr    [NS];

  function automatic logic [511:0] mkLine(int seed);
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = {seed[15:0], 16'(i)};
    return l;
  endfunction

  function automatic logic [31:0] va(int page, int idx, int word);
    return (32'(page) << 12) | (32'(idx) << 6) | (32'(word) << 2);
  endfunction

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One cycle: drive, predict, clock, compare
  task automatic step(input bit rv, input logic [31:0] vaddr, input logic [19:0] ppn,
                      input bit fv, input logic [31:0] pa, input logic [511:0] line,
                      input string tag);
    bit eV, eHit;
    int eWay;
    logic [31:0] eData;
    int s, wd, fs, victim;
    bit found;
    logic [19:0] ft;
    reqValid = rv; reqVaddr = vaddr; xlatPpn = ppn;
    refillValid = fv; refillPaddr = pa; refillLine = line;
    eV = rv; eHit = 0; eWay = 0; eData = '0;
    s  = int'(vaddr[10:6]);
    wd = int'(vaddr[5:2]);
    if (rv) begin
      for (int w = 0; w < NW; w++)
        if (mValid[w][s] && mTag[w][s] == ppn) begin
          eHit = 1; eWay = w; eData = mLine[w][s][wd*32 +: 32];
        end
    end
    if (fv) begin
      fs = int'(pa[10:6]); ft = pa[31:12]; found = 0; victim = 0;
      for (int w = 0; w < NW; w++)
        if (!found && mValid[w][fs] && mTag[w][fs] == ft) begin found = 1; victim = w; end
      for (int w = 0; w < NW; w++)
        if (!found && !mValid[w][fs]) begin found = 1; victim = w; end
      if (!found) begin victim = mRr[fs]; mRr[fs] = (mRr[fs] + 1) % NW; end
      mLine[victim][fs] = line; mTag[victim][fs] = ft; mValid[victim][fs] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== eV || rspHit !== eHit || rspWay !== 1'(eWay) || rspData !== eData) begin
      errors++;
      $display("FAIL %s: got v=%0b hit=%0b way=%0d data=%h, expected v=%0b hit=%0b way=%0d data=%h",
               tag, rspValid, rspHit, rspWay, rspData, eV, eHit, eWay, eData);
    end
  endtask

  task automatic idle(input string tag);
    step(0, '0, '0, 0, '0, '0, tag);
  endtask

  task automatic look(input int page, input int idx, input int word,
                      input int ppn, input string tag);
    step(1, va(page, idx, word), 20'(ppn), 0, '0, '0, tag);
  endtask

  task automatic fill(input int ppn, input int idx, input int seed, input string tag);
    step(0, '0, '0, 1, va(ppn, idx, 0), mkLine(seed), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < NW; w++) mValid[w][s] = 0;
    end
    rstN = 1'b0; reqValid = 0; reqVaddr = '0; xlatPpn = '0;
    refillValid = 0; refillPaddr = '0; refillLine = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b hit=%0b, expected 0 0", rspValid, rspHit);
    end
    idle("R1 idle after reset");
    look(5, 3, 0, 'h100, "R1 cold miss");
    look(5, 3, 7, 'h000, "R1/R5 cold miss ppn zero");

    // Fill into invalid ways, lowest first
    fill('h100, 3, 1, "R8 first fill");
    look(5, 3, 2, 'h100, "R4/R6 hit way0");
    fill('h200, 3, 2, "R8 second fill");
    look(9, 3, 15, 'h200, "R6/R8 hit way1");
    look(9, 3, 4, 'h300, "R5 miss full set");

    // Virtual page bits above the offset ignored
    step(1, va(5, 3, 6) | 32'h800, 20'h100, 0, '0, '0, "R3 bit11 set");
    look('hFFFFF, 3, 6, 'h100, "R3 other virtual page");
    look(5, 3, 6, 'h200, "R3 ppn chooses way");
    look(5, 4, 6, 'h100, "R3 other set misses");

    // Round-robin replacement
    fill('h300, 3, 3, "R9 rr replace way0");
    look(0, 3, 1, 'h100, "R9 evicted tag misses");
    look(0, 3, 1, 'h300, "R9 new tag way0");
    fill('h400, 3, 4, "R9 rr replace way1");
    look(0, 3, 9, 'h200, "R9 evicted way1");
    look(0, 3, 9, 'h400, "R9 new tag way1");
    fill('h500, 4, 5, "R9 set4 fill");
    fill('h600, 4, 6, "R9 set4 fill");
    fill('h700, 4, 7, "R9 set4 rr way0");
    fill('h800, 3, 8, "R9 set3 wraps to way0");
    look(0, 4, 0, 'h700, "R9 set4 independent");
    look(0, 4, 0, 'h600, "R9 set4 way1 kept");
    look(0, 3, 0, 'h800, "R9 set3 wrap");
    look(0, 3, 0, 'h400, "R9 set3 way1 kept");

    // Refill of a tag already present
    fill('h400, 3, 9, "R10 refill same tag");
    look(0, 3, 5, 'h400, "R10/R11 overwrite in place");
    look(0, 3, 5, 'h800, "R10 other way untouched");
    fill('h900, 3, 10, "R10 pointer not advanced");
    look(0, 3, 5, 'h400, "R10 rr evicts expected way");
    look(0, 3, 5, 'h900, "R10 rr new line");

    // Lookup and refill in the same cycle
    step(1, va(0, 7, 3), 20'h111, 1, va('h111, 7, 0), mkLine(11), "R7 same cycle sees old");
    look(0, 7, 3, 'h111, "R7 next cycle sees new");
    step(1, va(0, 3, 3), 20'h900, 1, va('h900, 3, 0), mkLine(12), "R7 old data same cycle");
    look(0, 3, 3, 'h900, "R7 new data after");

    // Back-to-back and gapped requests
    for (int i = 0; i < 16; i++) look(i, 7, i, 'h111, "R2/R4 back to back words");
    idle("R2 gap");
    look(1, 7, 15, 'h111, "R2 after gap");
    idle("R2 gap after request");

    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int idxs [3] = '{3, 4, 9};
      bit rv = ($urandom % 4) != 0;
      bit fv = ($urandom % 3) == 0;
      int ri = idxs[$urandom % 3];
      int fi = idxs[$urandom % 3];
      int rp = 'h100 + int'($urandom % 5);
      int fp = 'h100 + int'($urandom % 5);
      step(rv, va(int'($urandom % 1024), ri, int'($urandom % 16)), 20'(rp),
           fv, va(fp, fi, 0), mkLine(1000 + i), "R4/R9/R11 mixed");
    end

    report();
    $finish;
  end

endmodule